// File: doc/BRIEF.md
# FIR Multiply-Accumulate Sequencer with Circular Sample Window

This block computes one output of an n-tap FIR filter on request. Incoming samples go into a ring of n registers, and a write pointer that wraps modulo n always marks the oldest entry. Each new sample overwrites that entry, so the ring holds exactly the n most recent samples. Coefficients sit in a separate register file that is loaded through a small write port.

A start pulse clears the accumulator and loads the first operand pair: the newest sample and coefficient 0. The block then runs n multiply-accumulate steps. In each step the product of the held operands is added to the accumulator, and the next pair is fetched in the same cycle. The coefficient pointer counts up. The sample pointer counts down and wraps modulo n toward older samples.

When the last step is done, a one-cycle done strobe flags the result. The full-precision sum then stays on the result port until the next start.

Top module: `fir_mac_seq`

## Requirements
- R1: While idle, a sample presented with `smp_valid` replaces the oldest entry of the ring, and the write position wraps modulo TAPS. Each result therefore uses only the TAPS most recent accepted samples.
- R2: The result is sum over i = 0..TAPS-1 of a_i * x_(j-i). Here x_j is the newest accepted sample and a_i is the coefficient at address i. Samples and coefficients are DW-bit two's-complement values when SIGNED = 1.
- R3: The result is 2*DW + ceil(log2 TAPS) bits wide and never wraps, even when every product is at full scale.
- R4: A start while idle raises `busy` at the next edge. `busy` stays high for exactly TAPS cycles. `done` is then high for exactly one cycle, during which `busy` is low.
- R5: A start while busy has no effect: no extra done strobe and no change to the result.
- R6: Sample writes and coefficient writes presented while busy are dropped. They have no effect on that result or on later ones.
- R7: While idle and without a start, the result holds its value.
- R8: After reset, `busy`, `done` and `result` are 0, and every sample and coefficient entry is 0.
- R9: A coefficient write while idle stores `cf_data` at address `cf_addr`. Addresses at or above TAPS are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample write strobe |
| smp_data | input | DW | Sample value |
| cf_we | input | 1 | Coefficient write strobe |
| cf_addr | input | AW | Coefficient address (tap index) |
| cf_data | input | DW | Coefficient value |
| start | input | 1 | Begin one output computation |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | ACCW | Accumulated filter output |

## Verification
The bound checker watches the following on every cycle:
- the single-cycle width of `done` and that it never overlaps `busy`;
- a busy interval of exactly TAPS cycles before each strobe, measured with its own counter;
- the entry into busy after an idle start;
- the stability of the result while idle.

Other behaviours can only be shown by the bench's scenarios, because they depend on arithmetic or on history:
- the numeric value of each convolution, compared against a behavioural model of the sample history;
- the window sliding and wrapping across many samples;
- full-scale sums that would overflow a narrower accumulator;
- the dropping of writes and starts that arrive while busy.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
   parameter int DW   = 8,
   parameter int TAPS = 5,
   parameter int AW   = $clog2(TAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] newest
);
   logic [DW-1:0] slot [TAPS];
   logic [AW-1:0] oldest;

   // wr_ptr always names the oldest entry; the newest is one behind it
   assign newest  = (oldest == '0) ? AW'(TAPS - 1) : oldest - 1'b1;
   assign rd_data = slot[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oldest <= '0;
         for (int k = 0; k < TAPS; k++) slot[k] <= '0;
      end else if (wr_en) begin
         slot[oldest] <= wr_data;
         oldest       <= (oldest == AW'(TAPS - 1)) ? '0 : oldest + 1'b1;
      end
   end
endmodule

// File: rtl/fir_coef_file.sv
module fir_coef_file #(
   parameter int DW   = 8,
   parameter int TAPS = 5,
   parameter int AW   = $clog2(TAPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] coef [TAPS];
   logic          addr_ok;

   generate
      if (TAPS == (1 << AW)) begin : g_full_range
         assign addr_ok = 1'b1;
      end else begin : g_part_range
         assign addr_ok = ({1'b0, wr_addr} < (AW+1)'(TAPS));
      end
   endgenerate

   assign rd_data = coef[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++) coef[k] <= '0;
      end else if (wr_en && addr_ok) begin
         coef[wr_addr] <= wr_data;
      end
   end
endmodule

// File: rtl/fir_mac_ctl.sv
module fir_mac_ctl
   import fir_mac_pkg::*;
#(
   parameter int DW     = 8,
   parameter int TAPS   = 5,
   parameter int AW     = $clog2(TAPS),
   parameter int ACCW   = 2*DW + $clog2(TAPS),
   parameter bit SIGNED = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   newest,
   output logic [AW-1:0]   x_addr,
   input  logic [DW-1:0]   x_data,
   output logic [AW-1:0]   a_addr,
   input  logic [DW-1:0]   a_data,
   output logic            busy,
   output logic            done,
   output logic [ACCW-1:0] acc
);
   localparam int CW = (TAPS > 1) ? $clog2(TAPS) : 1;

   seq_state_e      state;
   logic [DW-1:0]   op_x, op_a;
   logic [AW-1:0]   x_ptr, a_ptr;
   logic [CW-1:0]   step;
   logic [2*DW-1:0] prod;
   logic [ACCW-1:0] prod_ext;

   function automatic logic [AW-1:0] ring_dec(input logic [AW-1:0] p);
      return (p == '0) ? AW'(TAPS - 1) : p - 1'b1;
   endfunction

   function automatic logic [AW-1:0] ring_inc(input logic [AW-1:0] p);
      return (p == AW'(TAPS - 1)) ? '0 : p + 1'b1;
   endfunction

   generate
      if (SIGNED) begin : g_signed
         assign prod     = $signed(op_x) * $signed(op_a);
         assign prod_ext = {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
      end else begin : g_unsigned
         assign prod     = op_x * op_a;
         assign prod_ext = {{(ACCW-2*DW){1'b0}}, prod};
      end
   endgenerate

   assign busy   = (state == SEQ_RUN);
   assign x_addr = busy ? x_ptr : newest;
   assign a_addr = busy ? a_ptr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         acc   <= '0;
         op_x  <= '0;
         op_a  <= '0;
         x_ptr <= '0;
         a_ptr <= '0;
         step  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SEQ_IDLE: if (start) begin
               acc   <= '0;
               op_x  <= x_data;
               op_a  <= a_data;
               x_ptr <= ring_dec(newest);
               a_ptr <= ring_inc('0);
               step  <= '0;
               state <= SEQ_RUN;
            end
            SEQ_RUN: begin
               // accumulate the held pair while the next pair is fetched
               acc   <= acc + prod_ext;
               op_x  <= x_data;
               op_a  <= a_data;
               x_ptr <= ring_dec(x_ptr);
               a_ptr <= ring_inc(a_ptr);
               if (step == CW'(TAPS - 1)) begin
                  state <= SEQ_IDLE;
                  done  <= 1'b1;
               end else begin
                  step <= step + 1'b1;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
   parameter int DW     = 8,
   parameter int TAPS   = 5,
   parameter bit SIGNED = 1'b1,
   parameter int AW     = $clog2(TAPS),
   parameter int ACCW   = 2*DW + $clog2(TAPS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic [DW-1:0]   smp_data,
   input  logic            cf_we,
   input  logic [AW-1:0]   cf_addr,
   input  logic [DW-1:0]   cf_data,
   input  logic            start,
   output logic            busy,
   output logic            done,
   output logic [ACCW-1:0] result
);
   generate
      if (TAPS < 2)        begin : g_bad_taps  $error("TAPS must be at least 2");             end
      if (DW < 2)          begin : g_bad_dw    $error("DW must be at least 2");               end
      if (AW != $clog2(TAPS)) begin : g_bad_aw $error("AW must equal clog2(TAPS)");          end
      if (ACCW < 2*DW + $clog2(TAPS)) begin : g_bad_acc $error("ACCW too narrow for TAPS sums"); end
   endgenerate

   logic [AW-1:0] newest, x_addr, a_addr;
   logic [DW-1:0] x_data, a_data;

   fir_sample_ring #(.DW(DW), .TAPS(TAPS), .AW(AW)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .wr_en(smp_valid && !busy), .wr_data(smp_data),
      .rd_addr(x_addr), .rd_data(x_data), .newest(newest)
   );

   fir_coef_file #(.DW(DW), .TAPS(TAPS), .AW(AW)) u_coef (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cf_we && !busy), .wr_addr(cf_addr), .wr_data(cf_data),
      .rd_addr(a_addr), .rd_data(a_data)
   );

   fir_mac_ctl #(.DW(DW), .TAPS(TAPS), .AW(AW), .ACCW(ACCW), .SIGNED(SIGNED)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .newest(newest),
      .x_addr(x_addr), .x_data(x_data), .a_addr(a_addr), .a_data(a_data),
      .busy(busy), .done(done), .acc(result)
   );
endmodule

// File: rtl/fir_mac_chk.sv
module fir_mac_chk #(
   parameter int TAPS = 5,
   parameter int ACCW = 19
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic [ACCW-1:0] result
);
   localparam int CW = $clog2(TAPS + 2) + 1;
   logic [CW-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_run == CW'(TAPS)));
   p_start_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));
endmodule

bind fir_mac_seq fir_mac_chk #(.TAPS(TAPS), .ACCW(ACCW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .busy(busy), .done(done), .result(result)
);

// File: tb/sim_fir_mac_seq.sv
module sim_fir_mac_seq;
   localparam int DW = 8, TAPS = 5, AW = 3, ACCW = 19;
   localparam int NV = 12;
   localparam int VEC [NV] = '{17, -3, 100, -128, 127, 5, -60, 0, 44, -1, 90, -77};

   logic clk = 1'b0, rst_n = 1'b0;
   logic smp_valid = 1'b0, cf_we = 1'b0, start = 1'b0;
   logic [DW-1:0] smp_data = '0, cf_data = '0;
   logic [AW-1:0] cf_addr = '0;
   logic busy, done;
   logic [ACCW-1:0] result;

   int checks = 0, fails = 0;
   int coef_m [TAPS];
   int hist [$];
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fir_mac_seq #(.DW(DW), .TAPS(TAPS)) u0 (
      .clk, .rst_n, .smp_valid, .smp_data, .cf_we, .cf_addr, .cf_data,
      .start, .busy, .done, .result
   );

   function automatic int model();
      int s = 0;
      for (int i = 0; i < TAPS; i++)
         if (i < hist.size()) s += coef_m[i] * hist[hist.size()-1-i];
      return s;
   endfunction

   function automatic int res_i();
      return int'($signed(result));
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(input int v);
      @(negedge clk) smp_valid = 1'b1; smp_data = DW'(v);
      @(negedge clk) smp_valid = 1'b0;
      hist.push_back(v);
   endtask

   task automatic wcoef(input int a, input int v);
      @(negedge clk) cf_we = 1'b1; cf_addr = AW'(a); cf_data = DW'(v);
      @(negedge clk) cf_we = 1'b0;
      if (a < TAPS) coef_m[a] = v;
   endtask

   // start, then count negedges until done; check busy length and pulse width
   task automatic run(input string req);
      int lat = 1, nbusy = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && lat < 40) begin
         if (busy) nbusy++;
         @(negedge clk) lat++;
      end
      chk(lat == TAPS + 1, "R4 latency", lat, TAPS + 1);
      chk(nbusy == TAPS, "R4 busy cycles", nbusy, TAPS);
      chk(res_i() == model(), req, res_i(), model());
      @(negedge clk);
      chk(!done, "R4 done width", int'(done), 0);
   endtask

   initial begin
      #1_500_000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int hold, nd;
      for (int i = 0; i < TAPS; i++) coef_m[i] = 0;
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R8 reset flags", int'({busy, done}), 0);
      chk(result == '0, "R8 reset result", res_i(), 0);
      rst_n = 1'b1;
      run("R8 zeroed storage result");

      // R9: coefficient load, plus an out-of-range address that must be dropped
      wcoef(0, 3); wcoef(1, -2); wcoef(2, 5); wcoef(3, 1); wcoef(4, -7);
      wcoef(7, 99);

      // R1 R2: vector table walk, window slides and wraps
      for (int v = 0; v < NV; v++) begin
         push(VEC[v]);
         run("R2 convolution value");
      end
      run("R9 out-of-range coefficient ignored");

      // R7: result held while idle
      hold = res_i();
      repeat (6) @(negedge clk);
      chk(res_i() == hold, "R7 idle hold", res_i(), hold);

      // R5 R6: start, sample and coef writes during busy
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b1; smp_valid = 1'b1; smp_data = 8'd77;
                     cf_we = 1'b1; cf_addr = '0; cf_data = 8'd100;
      @(negedge clk) start = 1'b0; smp_valid = 1'b0; cf_we = 1'b0;
      nd = 0;
      for (int c = 0; c < 3 * TAPS; c++) begin
         if (done) nd++;
         @(negedge clk);
      end
      chk(nd == 1, "R5 single done", nd, 1);
      chk(res_i() == model(), "R5 R6 result during busy", res_i(), model());
      run("R6 dropped writes absent later");

      // R3: full-scale sums
      for (int i = 0; i < TAPS; i++) wcoef(i, -128);
      for (int i = 0; i < TAPS; i++) push(-128);
      run("R3 max positive sum");
      chk(res_i() == TAPS * 16384, "R3 value", res_i(), TAPS * 16384);
      for (int i = 0; i < TAPS; i++) wcoef(i, 127);
      run("R3 max negative sum");
      chk(res_i() == -TAPS * 16256, "R3 value", res_i(), -TAPS * 16256);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule